// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave serial port through which an external master reads and writes a small bank of 8-bit configuration registers. A transaction is a fixed 24-bit frame that the master shifts in MSB-first. The frame holds a command byte, then a register address byte, then a data byte. Serial clock, chip select and serial data are oversampled by a faster system clock. They pass through a synchronizer, and the edges of the serial clock are detected on the system clock.

The frame bit counter is not cleared when chip select is released. A frame that stops short therefore leaves the port out of step with later frames. There are two ways to bring it back into step:
- Toggle serial clock with chip select released. The counter runs on to the frame boundary and then stays there. No register is touched.
- Pulse the hardware reset. This also restores every register to its default value.

Top module: `spi_cfg_port`

## Requirements
- R1: SDI is sampled on rising serial-clock edges and read data on SDO changes on falling edges (mode 0). All fields move MSB-first.
- R2: Command 0x02 writes the data byte into the addressed register, and the write happens only when the 24th bit is sampled with chip select low. A frame that ends before its 24th bit writes nothing.
- R3: Command 0x03 loads the addressed register into the output shifter once the address byte is complete. The value is then driven on SDO, MSB first, during the data byte.
- R4: Any command other than 0x02 or 0x03 changes no register.
- R5: Addresses at or above NUM_REGS read as 0x00, and writes to them are discarded.
- R6: The bit count advances only on rising serial-clock edges and is kept when chip select is released mid-frame. A later frame is then decoded out of step.
- R7: With chip select high, each rising edge advances a non-zero bit count until it reaches the frame boundary, where it stays. No write occurs, so 24 such edges always restore alignment and keep the registers unchanged.
- R8: While rst_n is low at a clock edge, the following happens: register n takes the value RST_PATTERN XOR n, the bit count returns to the frame boundary, and SDO goes low.
- R9: sdo_oe is high exactly while the synchronized chip select is low. SDO is low whenever it is not carrying read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| cs_n | input | 1 | Chip select from the master, active low |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial read data to the master |
| sdo_oe | output | 1 | Output enable for the SDO pad driver; low means high impedance |

## Verification
The bench builds the port with NUM_REGS = 6, RST_PATTERN = 8'hA5 and SYNC_STAGES = 2. With six registers, addresses 6, 7 and 0x80 fall outside the bank, so one address byte can reach both implemented and unimplemented locations. The XOR-based defaults give each register a distinct reset value, so a wrongly addressed read shows up. Two synchronizer stages keep the delay from a serial-clock edge to SDO well inside the bench's eight-cycle half period, so the read bits can be sampled at a single fixed point.

// File: rtl/spi_cfg_pkg.sv
// Package: shared frame geometry and command codes for the serial register port.
// Assumes byte-wide command, address and data fields.
package spi_cfg_pkg;
    localparam int CMD_W      = 8;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = CMD_W + ADDR_W + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int ADDR_DONE  = CMD_W + ADDR_W - 1;   // count value while last address bit is sampled
    localparam int FRAME_LAST = FRAME_BITS - 1;

    localparam logic [CMD_W-1:0] CMD_WRITE = 8'h02;
    localparam logic [CMD_W-1:0] CMD_READ  = 8'h03;
endpackage

// File: rtl/spi_cfg_sync.sv
// Module: brings sclk, cs_n and sdi into the system clock domain and flags
// serial-clock edges. Assumes sclk is at most a quarter of the clk rate.
module spi_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic sdi_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic sdi_s
);
    // bit 2 = sdi, bit 1 = cs_n, bit 0 = sclk
    localparam logic [2:0] IDLE_LINES = 3'b010;

    logic [2:0] pipe [STAGES];
    logic       sclk_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // first flop of each synchronizer chain
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[0] <= IDLE_LINES;
                    else        pipe[0] <= {sdi_in, cs_n_in, sclk_in};
                end
            end else begin : g_next
                // further flops of each synchronizer chain
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= IDLE_LINES;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    // remember the last synchronized sclk level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= pipe[STAGES-1][0];
    end

    // decode edges and present synchronized levels
    always_comb begin
        sclk_rise = pipe[STAGES-1][0] & ~sclk_prev;
        sclk_fall = ~pipe[STAGES-1][0] & sclk_prev;
        cs_act    = ~pipe[STAGES-1][1];
        sdi_s     = pipe[STAGES-1][2];
    end
endmodule

// File: rtl/spi_cfg_frame.sv
// Module: counts frame bits, collects the incoming bits and decodes the
// command. Assumes edge pulses last one clk. The count is never cleared by
// chip select.
module spi_cfg_frame
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              cs_act,
    input  logic              sdi_s,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_load,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              frame_end
);
    logic [FRAME_BITS-2:0] bits_q;
    logic                  at_last;
    logic                  at_addr_done;

    assign at_last      = (bit_cnt == CNT_W'(FRAME_LAST));
    assign at_addr_done = (bit_cnt == CNT_W'(ADDR_DONE));

    // shift in bits and advance the count (flush: run on to the boundary only)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            bits_q  <= '0;
        end else if (rise) begin
            bits_q <= {bits_q[FRAME_BITS-3:0], sdi_s};
            if (cs_act || bit_cnt != '0)
                bit_cnt <= at_last ? '0 : bit_cnt + 1'b1;
        end
    end

    // decode the command at the address boundary and at the frame end
    always_comb begin
        wr_addr   = bits_q[DATA_W+ADDR_W-2 -: ADDR_W];
        wr_data   = {bits_q[DATA_W-2:0], sdi_s};
        rd_addr   = {bits_q[ADDR_W-2:0], sdi_s};
        frame_end = rise & at_last;
        wr_en     = rise & cs_act & at_last &
                    (bits_q[FRAME_BITS-2 -: CMD_W] == CMD_WRITE);
        rd_load   = rise & cs_act & at_addr_done &
                    (bits_q[ADDR_W+CMD_W-2 -: CMD_W] == CMD_READ);
    end

    // R8
    cnt_reset_chk: assert property (@(posedge clk) !rst_n |=> (bit_cnt == '0));
    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(bit_cnt));
    // R7
    flush_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && bit_cnt == '0) |=> (bit_cnt == '0));
endmodule

// File: rtl/spi_cfg_regs.sv
// Module: configuration register bank with computed reset defaults.
// Assumes addresses at or above NUM_REGS are not implemented.
module spi_cfg_regs
    import spi_cfg_pkg::*;
#(
    parameter int              NUM_REGS    = 8,
    parameter logic [DATA_W-1:0] RST_PATTERN = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    // reset to defaults, commit a write to an implemented address
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n)
                regs[i] <= RST_PATTERN ^ DATA_W'(i);
            else if (wr_en && wr_addr == ADDR_W'(i))
                regs[i] <= wr_data;
        end
    end

    // read mux, zero for unimplemented addresses
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
    end

    // R2
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));
endmodule

// File: rtl/spi_cfg_sdo.sv
// Module: read-data shifter driving SDO on falling serial-clock edges.
// Assumes load, frame end and falling edge never coincide.
module spi_cfg_sdo
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic              rd_load,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              frame_end,
    input  logic              cs_act,
    output logic              sdo,
    output logic              rd_active
);
    logic [DATA_W-1:0] shift_q;

    // load, retire and shift the read byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q   <= '0;
            rd_active <= 1'b0;
            sdo       <= 1'b0;
        end else if (rd_load) begin
            shift_q   <= rd_data;
            rd_active <= 1'b1;
        end else if (frame_end) begin
            rd_active <= 1'b0;
        end else if (fall) begin
            if (rd_active && cs_act) begin
                sdo     <= shift_q[DATA_W-1];
                shift_q <= {shift_q[DATA_W-2:0], 1'b0};
            end else begin
                sdo <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_cfg_port.sv
// Module: top of the serial configuration port. Oversamples the serial lines
// on clk. Assumes sclk is at most a quarter of the clk rate and rst_n is
// synchronous to clk.
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter int                NUM_REGS    = 8,
    parameter logic [DATA_W-1:0] RST_PATTERN = 8'hA5,
    parameter int                SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);
    logic              sclk_rise, sclk_fall, cs_act, sdi_s;
    logic [CNT_W-1:0]  bit_cnt;
    logic              wr_en, rd_load, frame_end, rd_active;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .cs_n_in(cs_n), .sdi_in(sdi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .sdi_s(sdi_s)
    );

    spi_cfg_frame u_frame (
        .clk(clk), .rst_n(rst_n), .rise(sclk_rise), .cs_act(cs_act), .sdi_s(sdi_s),
        .bit_cnt(bit_cnt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_load(rd_load), .rd_addr(rd_addr), .frame_end(frame_end)
    );

    spi_cfg_regs #(.NUM_REGS(NUM_REGS), .RST_PATTERN(RST_PATTERN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    spi_cfg_sdo u_sdo (
        .clk(clk), .rst_n(rst_n), .fall(sclk_fall), .rd_load(rd_load),
        .rd_data(rd_data), .frame_end(frame_end), .cs_act(cs_act),
        .sdo(sdo), .rd_active(rd_active)
    );

    // pad enable follows the synchronized chip select
    assign sdo_oe = cs_act;

    // R3
    rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt < CNT_W'(ADDR_DONE + 1)) |-> !rd_active);
endmodule

// File: tb/sim_spi_cfg_port.sv
module sim_spi_cfg_port;
    localparam int HALF = 8;   // clk cycles per sclk half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_oe;
    int   n_chk = 0;
    int   n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    spi_cfg_port #(.NUM_REGS(6), .RST_PATTERN(8'hA5), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // shift the first n bits of word MSB-first; rd collects SDO during bits 16..23
    task automatic clock_bits(input logic sel, input logic [23:0] word, input int n,
                              output logic [7:0] rd);
        rd = '0;
        @(negedge clk);
        cs_n = ~sel;
        wait_clk(HALF);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            sdi  = word[23-i];
            wait_clk(HALF);
            if (i >= 16) rd = {rd[6:0], sdo};
            sclk = 1'b1;
            wait_clk(HALF);
        end
        sclk = 1'b0;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic pulse_reset;
        @(negedge clk);
        rst_n = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
    endtask

    // {command, address, data, expected SDO byte}
    localparam logic [31:0] VEC [13] = '{
        32'h03_00_00_A5,   // R3 default of reg 0
        32'h03_05_00_A0,   // R3 R8 default of reg 5
        32'h02_01_3C_00,   // R2 write, R9 SDO low
        32'h03_01_00_3C,   // R2 R1 read back
        32'h02_05_C3_00,   // R2 write last register
        32'h03_05_00_C3,   // R3
        32'h07_02_FF_00,   // R4 unknown command
        32'h03_02_00_A7,   // R4 reg 2 unchanged
        32'h02_06_55_00,   // R5 write outside the bank
        32'h03_06_00_00,   // R5 reads zero
        32'h03_80_00_00,   // R5 high address
        32'h82_03_11_00,   // R4 near-miss command
        32'h03_03_00_A6    // R4 reg 3 unchanged
    };

    initial begin
        logic [7:0] rd;
        wait_clk(5);
        // R8 R9 reset state
        check("R9 sdo_oe idle", {7'b0, sdo_oe}, 8'h00);
        check("R8 sdo after reset", {7'b0, sdo}, 8'h00);
        rst_n = 1'b1;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(6);
        check("R9 sdo_oe with cs low", {7'b0, sdo_oe}, 8'h01);
        cs_n = 1'b1;
        wait_clk(6);
        check("R9 sdo_oe after cs release", {7'b0, sdo_oe}, 8'h00);

        // table walk: R1 R2 R3 R4 R5 R9
        for (int v = 0; v < 13; v++) begin
            clock_bits(1'b1, VEC[v][31:8], 24, rd);
            check($sformatf("R1/R2/R3/R4/R5 vector %0d", v), rd, VEC[v][7:0]);
        end

        // R2 R7: 23-bit write, then one flush edge finishes the frame with no write
        clock_bits(1'b1, 24'h02_04_5A, 23, rd);
        clock_bits(1'b0, 24'hFF_FF_FF, 1, rd);
        clock_bits(1'b1, 24'h03_04_00, 24, rd);
        check("R2 short frame no write", rd, 8'hA1);

        // R6: 8 partial zero bits, then a write frame is decoded out of step
        clock_bits(1'b1, 24'h00_00_00, 8, rd);
        clock_bits(1'b1, 24'h02_02_3C, 24, rd);
        // R7: flush with write-looking bits and chip select high
        clock_bits(1'b0, 24'h02_02_EE, 24, rd);
        clock_bits(1'b1, 24'h03_02_00, 24, rd);
        check("R6 misaligned write lost", rd, 8'hA7);
        clock_bits(1'b1, 24'h02_02_99, 24, rd);
        clock_bits(1'b1, 24'h03_02_00, 24, rd);
        check("R7 aligned after flush", rd, 8'h99);

        // R8: partial frame, then reset restores defaults and alignment
        clock_bits(1'b1, 24'h03_00_00, 5, rd);
        pulse_reset();
        clock_bits(1'b1, 24'h03_01_00, 24, rd);
        check("R8 default after reset", rd, 8'hA4);
        clock_bits(1'b1, 24'h03_02_00, 24, rd);
        check("R8 reg 2 default", rd, 8'hA7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule